// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous static RAM of 32,768 words by 8 bits. The host issues one read or one write at a time with a request strobe, a write flag, a 15-bit address and an 8-bit write word. The block converts each request into a sequence of chip-enable, output-enable and write-enable strobes, all active low, on the memory pins. Every strobe and the address are registered.

The access, pulse-width and bus-release limits of the memory are parameters in nanoseconds, as is the system clock period. They are turned into whole cycle counts rounded up, and one down-counter times every phase. Reads hold chip enable and output enable low until the slowest access limit has passed. The data bus is then sampled on the same edge that releases the strobes. Writes are write-enable controlled, with output enable held high, and the block drives the data bus only while the write strobe is low. A write that follows a read first waits out the memory's output release time. Between accesses the memory is left in standby.

The data bus leaves the block as separate out, enable and in signals, so the tristate pad can live in the chip's I/O ring.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever `busy` is low, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1 and `sram_dq_oe` is 0.
- R2: A read accepted on edge k drives `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with the request address for exactly RD cycles after that edge. RD is the largest of ceil(35 ns/period), ceil(35 ns/period) and ceil(25 ns/period), which is 5 at an 8 ns clock.
- R3: The bus value present on the last read-strobe cycle is captured on the edge that raises the strobes. In the following cycle `done`=1, `busy`=0 and `rdata` holds that value. `done` lasts exactly one cycle.
- R4: A write drives `sram_ce_n`=0, `sram_we_n`=0 and `sram_oe_n`=1, with `sram_dq_oe`=1 and the write word on `sram_dq_out`, for exactly WR cycles. WR is the largest of ceil(35/period), ceil(30/period), ceil(25/period) and ceil(20/period), which is 5 at 8 ns. It is followed by a one-cycle `done`.
- R5: When the previous access was a read, a write first spends TA = ceil(25 ns/period) cycles (4 at 8 ns) with `busy`=1, all strobes high and the driver off.
- R6: A write after a write, and a read after either kind of access, starts its strobes on the cycle right after acceptance, with no turnaround.
- R7: A request is accepted only in a cycle where `busy` is 0. Requests raised while `busy` is 1 leave the strobes, the address, the data and the timing of the access in flight unchanged.
- R8: While chip enable stays low, `sram_addr` does not change, and while the driver stays on, `sram_dq_out` does not change.
- R9: `sram_dq_oe` is never 1 while `sram_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when `busy` is low |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Word to write |
| busy | output | 1 | Access in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Word read, valid with `done` after a read |
| sram_addr | output | 15 | Memory address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Data to the bus pad |
| sram_dq_oe | output | 1 | Bus pad driver enable |
| sram_dq_in | input | 8 | Data from the bus pad |

## Verification
The properties assume that reset is held long enough for the registered strobes to settle high. They also assume that the host treats `busy` as the only acceptance condition. Stray requests during an access are legal and must be ignored, so the stimulus raises them on purpose in several busy cycles of reads and writes. The memory model in the bench drives the bus only under a true read encoding. This keeps the contention check meaningful while the controller's driver stays under its own control. Request inputs change a quarter cycle after the clock edge and are therefore stable when sampled.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } ctl_state_t;

  // Whole cycles covering a time in ns, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Phase down-counter: loaded at each phase start, reports when the
// current cycle is the last of the phase.
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
// Access sequencer: chooses the phase, loads the timer and registers the
// strobes from the next state so the pins change only on clock edges.
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 4,
  parameter int TA_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             phase_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             busy,
  output logic             done,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drv
);

  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

  ctl_state_t state_q, state_d;
  logic       after_rd_q;
  logic       finish;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    finish   = 1'b0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (!req_wr) begin
            state_d = ST_READ;
            tmr_val = RD_LD;
          end else if (after_rd_q) begin
            state_d = ST_TURN;
            tmr_val = TA_LD;
          end else begin
            state_d = ST_WRITE;
            tmr_val = WR_LD;
          end
        end
      end
      ST_TURN: begin
        if (phase_last) begin
          state_d  = ST_WRITE;
          tmr_load = 1'b1;
          tmr_val  = WR_LD;
        end
      end
      ST_READ, ST_WRITE: begin
        if (phase_last) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign capture = finish && (state_q == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      after_rd_q <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      ce_n       <= 1'b1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      drv        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (finish) begin
        after_rd_q <= (state_q == ST_READ);
      end
      busy <= (state_d != ST_IDLE);
      done <= finish;
      ce_n <= !((state_d == ST_READ) || (state_d == ST_WRITE));
      oe_n <= (state_d != ST_READ);
      we_n <= (state_d != ST_WRITE);
      drv  <= (state_d == ST_WRITE);
    end
  end

endmodule

// File: rtl/sram_ctl_io.sv
// Address, write-data and read-capture registers.
module sram_ctl_io #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      dq_out <= '0;
    end else if (accept) begin
      addr   <= req_addr;
      dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int T_RC_NS  = 35,
  parameter int T_AA_NS  = 35,
  parameter int T_OE_NS  = 25,
  parameter int T_WC_NS  = 35,
  parameter int T_AW_NS  = 30,
  parameter int T_WP_NS  = 25,
  parameter int T_DW_NS  = 20,
  parameter int T_REL_NS = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int RD_CYC = max2(ns_to_cyc(T_RC_NS, CLK_NS),
                               max2(ns_to_cyc(T_AA_NS, CLK_NS),
                                    ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int WR_CYC = max2(max2(ns_to_cyc(T_WC_NS, CLK_NS),
                                    ns_to_cyc(T_AW_NS, CLK_NS)),
                               max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                    ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int TA_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
  localparam int CNT_MAX = max2(RD_CYC, max2(WR_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             phase_last;
  logic             accept;
  logic             capture;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (phase_last)
  );

  sram_ctl_fsm #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_wr     (req_wr),
    .phase_last (phase_last),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .capture    (capture),
    .busy       (busy),
    .done       (done),
    .ce_n       (sram_ce_n),
    .oe_n       (sram_oe_n),
    .we_n       (sram_we_n),
    .drv        (sram_dq_oe)
  );

  sram_ctl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .dq_in     (sram_dq_in),
    .addr      (sram_addr),
    .dq_out    (sram_dq_out),
    .rdata     (rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 4,
  parameter int TA_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_out
);

  logic [15:0] we_len, rd_len, gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_len <= '0;
      rd_len <= '0;
      gap    <= 16'(TA_CYC);
    end else begin
      we_len <= !we_n ? we_len + 16'd1 : 16'd0;
      rd_len <= !oe_n ? rd_len + 16'd1 : 16'd0;
      if (!oe_n) gap <= '0;
      else if (gap < 16'(TA_CYC)) gap <= gap + 16'd1;
    end
  end

  p_standby_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ce_n && oe_n && we_n && !dq_oe));

  p_read_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (rd_len == 16'(RD_CYC)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_write_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_len == 16'(WR_CYC)));

  p_write_oe_high_r4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && dq_oe && !ce_n));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (gap >= 16'(TA_CYC)));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  p_wdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe);

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RD_CYC (RD_CYC),
  .WR_CYC (WR_CYC),
  .TA_CYC (TA_CYC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .ce_n   (sram_ce_n),
  .oe_n   (sram_oe_n),
  .we_n   (sram_we_n),
  .dq_oe  (sram_dq_oe),
  .addr   (sram_addr),
  .dq_out (sram_dq_out)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

  // 8 ns clock: R2 ceil(35/8)=5, R4 ceil(35/8)=5, R5 ceil(25/8)=4
  localparam int RD = 5;
  localparam int WR = 5;
  localparam int TA = 4;

  typedef struct packed {
    logic        busy, ce_n, oe_n, we_n, drv, done, chk_rd;
    logic [14:0] addr;
    logic [7:0]  wd, rd;
    logic [3:0]  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic busy, done, ce_n, oe_n, we_n, dq_oe;
  logic [7:0] rdata, dq_out, dq_in;
  logic [14:0] addr;

  int checks = 0, fails = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  exp_t exp_q[$];
  logic [7:0] ref_mem [int];
  logic [7:0] sram_mem [int];
  bit ref_after_rd = 1'b0;

  always #4 clk = ~clk;

  sram_ctl #(.CLK_NS(8)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .sram_addr(addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
  );

  function automatic logic [7:0] fill(input logic [14:0] a);
    return a[7:0] ^ {a[14:11], 4'h9};
  endfunction

  // Memory model: drives only under a true read encoding.
  logic mem_drv;
  always_comb begin
    mem_drv = !ce_n && !oe_n && we_n;
    if (mem_drv) dq_in = sram_mem.exists(int'(addr)) ? sram_mem[int'(addr)] : fill(addr);
    else if (dq_oe) dq_in = dq_out;
    else dq_in = 8'h00;
  end

  always @(negedge clk) begin
    if (!ce_n && !we_n && dq_oe) sram_mem[int'(addr)] = dq_out;
  end

  function automatic exp_t mk(input logic b, ce, oe, we, dv, dn, cr,
                              input logic [14:0] a, input logic [7:0] w, r,
                              input logic [3:0] t);
    exp_t e;
    e.busy = b; e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.drv = dv;
    e.done = dn; e.chk_rd = cr; e.addr = a; e.wd = w; e.rd = r; e.tag = t;
    return e;
  endfunction

  task automatic check(input bit ok, input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the queued expectation (R1 when idle).
  always @(negedge clk) begin
    if (running && !finished) begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, 4'd1);
      check({busy, ce_n, oe_n, we_n, dq_oe, done} == {e.busy, e.ce_n, e.oe_n, e.we_n, e.drv, e.done},
            int'(e.tag), "ctrl{busy,ce,oe,we,drv,done}",
            {26'd0, busy, ce_n, oe_n, we_n, dq_oe, done},
            {26'd0, e.busy, e.ce_n, e.oe_n, e.we_n, e.drv, e.done});
      if (!e.ce_n) check(addr == e.addr, int'(e.tag), "addr", {17'd0, addr}, {17'd0, e.addr});
      if (e.drv) check(dq_out == e.wd, int'(e.tag), "wdata", {24'd0, dq_out}, {24'd0, e.wd});
      if (e.chk_rd) check(rdata == e.rd, int'(e.tag), "rdata", {24'd0, rdata}, {24'd0, e.rd});
      check(!(mem_drv && dq_oe), 9, "contention", {31'd0, dq_oe}, 32'd0);
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Issue one access; pokes>0 raises stray requests while busy (R7).
  task automatic op(input bit wr, input logic [14:0] a, input logic [7:0] d, input int pokes);
    logic [3:0] t;
    while (exp_q.size() > 1) begin @(posedge clk); #2; end
    if (exp_q.size() == 0) exp_q.push_back(mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, 4'd1));
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    if (wr) begin
      if (ref_after_rd)   // R5 turnaround
        repeat (TA) exp_q.push_back(mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, 4'd5));
      t = (pokes > 0) ? 4'd7 : (ref_after_rd ? 4'd5 : 4'd4);
      repeat (WR) exp_q.push_back(mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, d, '0, t));
      exp_q.push_back(mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, '0, 4'd4));
      ref_mem[int'(a)] = d;
      ref_after_rd = 1'b0;
    end else begin
      t = (pokes > 0) ? 4'd7 : 4'd2;
      repeat (RD) exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, '0, '0, t));
      exp_q.push_back(mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0, '0,
                         ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(a), 4'd3));
      ref_after_rd = 1'b1;
    end
    @(posedge clk); #2;
    req = 1'b0;
    for (int i = 0; i < pokes; i++) begin
      if (exp_q.size() > 1 && exp_q[0].busy) begin
        req = 1'b1; req_wr = ~wr; req_addr = ~a; req_wdata = ~d;
      end
      @(posedge clk); #2;
      req = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check({busy, ce_n, oe_n, we_n, dq_oe, done} == 6'b011100, 1, "reset ctrl",
          {26'd0, busy, ce_n, oe_n, we_n, dq_oe, done}, 32'b011100);
    @(posedge clk); #2;
    rst = 1'b0;
    running = 1'b1;
    repeat (3) begin @(posedge clk); #2; end

    op(1'b1, 15'h0000, 8'h00, 0);       // R4 write, no prior read
    op(1'b1, 15'h7FFF, 8'hFF, 0);       // R6 write after write
    op(1'b1, 15'h1234, 8'hA5, 0);
    op(1'b0, 15'h7FFF, 8'h00, 0);       // R2/R3 read after write, R6
    op(1'b0, 15'h0000, 8'h00, 0);       // back-to-back reads
    op(1'b0, 15'h1234, 8'h00, 0);
    op(1'b1, 15'h4321, 8'h3C, 0);       // R5 write after read
    op(1'b0, 15'h4321, 8'h00, 3);       // R7 stray requests during read
    op(1'b1, 15'h0101, 8'h96, 4);       // R7 during turnaround and write
    op(1'b0, 15'h0555, 8'h00, 0);       // unwritten location
    repeat (6) begin @(posedge clk); #2; end
    op(1'b1, 15'h0555, 8'h5A, 0);       // R5 after idle gap
    op(1'b0, 15'h0555, 8'h00, 0);
    op(1'b0, 15'h0101, 8'h00, 0);
    while (exp_q.size() > 0) begin @(posedge clk); #2; end
    repeat (4) begin @(posedge clk); #2; end
    report();
  end

endmodule